// File: doc/BRIEF.md
# CCC Message Framing Sequencer

This block sits on the controller side of an I3C SDR engine. It takes one message descriptor at a time and turns it into the ordered run of bus symbols that a line-level serializer then drives onto the wires. A descriptor carries four fields: a message type, an 8-bit CCC code, a linear byte count and an end-type bit. A static configuration input chooses whether the arbitrable broadcast header follows a START.

The block remembers whether the bus was left idle after a STOP or held by a repeated START. That memory decides how the next message opens. Data bytes for the message are pulled from a byte stream with valid/ready handshaking. Symbols leave through a second valid/ready port as a 3-bit kind plus an 8-bit payload. Descriptors with a reserved type, and ENTDAA descriptors that carry data, are refused. A refusal raises an error pulse and produces no bus activity.

Top module: `ccc_frame_seq`

## Requirements
- R1: A descriptor with type 6 is taken as a CCC message. Any other type value is refused. On a refusal, `err_o` is high for the one cycle after the accepting edge, and no symbol is emitted. `busy_o` stays low.
- R2: A descriptor with CCC code 0x07 (ENTDAA) is refused in the same way as in R1 when its byte count is not zero. With a count of zero it is accepted.
- R3: If the bus is idle (after reset or after a STOP), a message opens with START (kind 0). START is followed by the header symbol (kind 3, payload 0xFC, which is address 0x7E with RnW=0), unless the no-header flag is set. When the flag is set, the header is left out.
- R4: If the previous message ended with a repeated START, the next message opens directly with the header symbol (kind 3, payload 0xFC). This happens whatever the no-header flag says.
- R5: The CCC byte (kind 4, payload = code) comes next. It is followed by a T symbol (kind 6). The T symbol's payload bit 0 is the odd-parity bit of the byte (the inverse of its XOR reduction), and bits 7:1 are zero.
- R6: After the CCC's T symbol come exactly `count` data symbols (kind 5). Each one takes its payload from the byte input, in order, and each is followed by its own odd-parity T symbol. A count of 0 gives no data symbols. `byte_ready_o` is high only while a data symbol is offered and the sink is ready.
- R7: A direct CCC (code bit 7 = 1) always ends with a repeated START (kind 1), whatever the end-type bit says.
- R8: A broadcast CCC (code bit 7 = 0) ends with a repeated START when the end-type bit is 0. It ends with STOP (kind 2) when the bit is 1, and the bus then counts as idle.
- R9: While a symbol other than data is offered and not accepted, its kind and payload stay unchanged.
- R10: Out of reset, the block is idle: `busy_o`=0, `sym_valid_o`=0, `err_o`=0 and `desc_ready_o`=1. `busy_o` rises at the accepting edge and falls at the edge where the end symbol is accepted. `desc_ready_o` is the inverse of `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be taken |
| desc_type_i | input | TYPE_W | Message type |
| desc_ccc_i | input | 8 | CCC code |
| desc_cnt_i | input | CNT_W | Data byte count |
| desc_end_i | input | 1 | End type: 1 = STOP, 0 = repeated START |
| no_hdr_i | input | 1 | Leave out the header after START |
| byte_valid_i | input | 1 | Data byte offered |
| byte_i | input | 8 | Data byte |
| byte_ready_o | output | 1 | Data byte consumed |
| sym_valid_o | output | 1 | Symbol offered |
| sym_kind_o | output | 3 | Symbol kind |
| sym_data_o | output | 8 | Symbol payload |
| sym_ready_i | input | 1 | Serializer takes symbol |
| busy_o | output | 1 | Message in progress |
| err_o | output | 1 | Descriptor refused pulse |

## Verification
The first symbol of an accepted message is offered in the cycle after the accepting edge. Each later symbol appears in the cycle after the edge where the one before it was taken. `busy_o` drops on the edge that takes the end symbol. `err_o` is high only in the single cycle after a refused descriptor's accepting edge. The bench drives every input on the falling edge and samples one time unit later, so the comparison is made against what the rising edge will take. Expected symbol lists are built arithmetically from the descriptor and from the bench's own record of the bus state. The symbol ready and byte valid inputs are stalled on a fixed pattern. This exercises hold behaviour. It also checks that no extra symbol follows the end symbol.

// File: rtl/ccc_frame_pkg.sv
package ccc_frame_pkg;
  typedef enum logic [2:0] {
    SYM_START  = 3'd0,
    SYM_RSTART = 3'd1,
    SYM_STOP   = 3'd2,
    SYM_HDR    = 3'd3,
    SYM_CCC    = 3'd4,
    SYM_DATA   = 3'd5,
    SYM_TBIT   = 3'd6
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_CCC, ST_CTB, ST_DATA, ST_DTB, ST_END
  } seq_state_e;

  localparam logic [6:0] BCAST_ADDR  = 7'h7E;
  localparam logic [7:0] HDR_BYTE    = {BCAST_ADDR, 1'b0};
  localparam logic [7:0] ENTDAA_CODE = 8'h07;
endpackage

// File: rtl/ccc_desc_check.sv
module ccc_desc_check #(
  parameter int unsigned TYPE_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CCC_TYPE = 6
) (
  input  logic [TYPE_W-1:0] type_i,
  input  logic [7:0]        ccc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              end_i,
  output logic              legal_o,
  output logic              end_stop_o
);
  import ccc_frame_pkg::*;

  logic type_ok, daa_ok;

  assign type_ok    = (type_i == TYPE_W'(CCC_TYPE));
  // ENTDAA carries no payload
  assign daa_ok     = (ccc_i != ENTDAA_CODE) || (cnt_i == '0);
  assign legal_o    = type_ok && daa_ok;
  // direct first part always hands over with Sr
  assign end_stop_o = end_i && !ccc_i[7];
endmodule

// File: rtl/ccc_odd_parity.sv
module ccc_odd_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         tbit_o
);
  assign tbit_o = ~(^data_i);
endmodule

// File: rtl/ccc_byte_counter.sv
module ccc_byte_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ccc_frame_seq.sv
module ccc_frame_seq #(
  parameter int unsigned TYPE_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CCC_TYPE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [TYPE_W-1:0] desc_type_i,
  input  logic [7:0]        desc_ccc_i,
  input  logic [CNT_W-1:0]  desc_cnt_i,
  input  logic              desc_end_i,
  input  logic              no_hdr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic              sym_valid_o,
  output logic [2:0]        sym_kind_o,
  output logic [7:0]        sym_data_o,
  input  logic              sym_ready_i,
  output logic              busy_o,
  output logic              err_o
);
  import ccc_frame_pkg::*;

  seq_state_e state_q, state_d;
  sym_kind_e  kind;
  logic       bus_idle_q, end_stop_q, no_hdr_q, tbit_q, err_q;
  logic [7:0] ccc_q;
  logic       legal, end_stop, accept, fire, tbit_nx;
  logic       cnt_zero, cnt_last, cnt_dec;
  logic [7:0] par_in;

  ccc_desc_check #(.TYPE_W(TYPE_W), .CNT_W(CNT_W), .CCC_TYPE(CCC_TYPE)) u_check (
    .type_i    (desc_type_i),
    .ccc_i     (desc_ccc_i),
    .cnt_i     (desc_cnt_i),
    .end_i     (desc_end_i),
    .legal_o   (legal),
    .end_stop_o(end_stop)
  );

  assign par_in = (state_q == ST_DATA) ? byte_i : ccc_q;

  ccc_odd_parity #(.W(8)) u_par (
    .data_i(par_in),
    .tbit_o(tbit_nx)
  );

  assign accept  = desc_valid_i && desc_ready_o;
  assign cnt_dec = fire && (state_q == ST_DTB);

  ccc_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && legal),
    .load_val_i(desc_cnt_i),
    .dec_i     (cnt_dec),
    .zero_o    (cnt_zero),
    .last_o    (cnt_last)
  );

  // symbol presentation
  always_comb begin
    sym_valid_o = 1'b1;
    kind        = SYM_START;
    sym_data_o  = 8'h00;
    unique case (state_q)
      ST_IDLE:  sym_valid_o = 1'b0;
      ST_START: kind = SYM_START;
      ST_HDR: begin
        kind       = SYM_HDR;
        sym_data_o = HDR_BYTE;
      end
      ST_CCC: begin
        kind       = SYM_CCC;
        sym_data_o = ccc_q;
      end
      ST_CTB, ST_DTB: begin
        kind       = SYM_TBIT;
        sym_data_o = {7'b0, tbit_q};
      end
      ST_DATA: begin
        kind        = SYM_DATA;
        sym_valid_o = byte_valid_i;
        sym_data_o  = byte_i;
      end
      ST_END: kind = end_stop_q ? SYM_STOP : SYM_RSTART;
      default: sym_valid_o = 1'b0;
    endcase
  end

  assign sym_kind_o   = kind;
  assign fire         = sym_valid_o && sym_ready_i;
  assign byte_ready_o = (state_q == ST_DATA) && sym_ready_i;
  assign busy_o       = (state_q != ST_IDLE);
  assign desc_ready_o = !busy_o;
  assign err_o        = err_q;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (accept && legal) state_d = bus_idle_q ? ST_START : ST_HDR;
    end else if (fire) begin
      unique case (state_q)
        ST_START: state_d = no_hdr_q ? ST_CCC : ST_HDR;
        ST_HDR:   state_d = ST_CCC;
        ST_CCC:   state_d = ST_CTB;
        ST_CTB:   state_d = cnt_zero ? ST_END : ST_DATA;
        ST_DATA:  state_d = ST_DTB;
        ST_DTB:   state_d = cnt_last ? ST_END : ST_DATA;
        ST_END:   state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bus_idle_q <= 1'b1;
      end_stop_q <= 1'b0;
      no_hdr_q   <= 1'b0;
      ccc_q      <= 8'h00;
      tbit_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept && !legal;
      if (accept && legal) begin
        ccc_q      <= desc_ccc_i;
        end_stop_q <= end_stop;
        no_hdr_q   <= no_hdr_i;
      end
      if (fire && (state_q == ST_CCC || state_q == ST_DATA)) tbit_q <= tbit_nx;
      if (fire && state_q == ST_END) bus_idle_q <= end_stop_q;
    end
  end
endmodule

// File: rtl/ccc_frame_seq_chk.sv
module ccc_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       desc_ready_o,
  input logic       byte_ready_o,
  input logic       sym_valid_o,
  input logic [2:0] sym_kind_o,
  input logic [7:0] sym_data_o,
  input logic       sym_ready_i,
  input logic       busy_o,
  input logic       err_o
);
  // R10
  busy_blocks_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !desc_ready_o);

  // R1
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!sym_valid_o && !busy_o));

  // R9
  sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i && sym_kind_o != 3'd5)
      |=> (sym_valid_o && $stable(sym_kind_o) && $stable(sym_data_o)));

  // R3
  hdr_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && sym_kind_o == 3'd3) |-> sym_data_o == 8'hFC);

  // R5
  ccc_then_t_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && sym_ready_i && sym_kind_o == 3'd4)
      |=> (sym_valid_o && sym_kind_o == 3'd6));

  // R6
  byte_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (busy_o && sym_kind_o == 3'd5));
endmodule

bind ccc_frame_seq ccc_frame_seq_chk chk_i (.*);

// File: tb/ccc_frame_seq_tb.sv
module ccc_frame_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       desc_valid_i = 1'b0;
  logic       desc_ready_o;
  logic [3:0] desc_type_i = '0;
  logic [7:0] desc_ccc_i = '0;
  logic [15:0] desc_cnt_i = '0;
  logic       desc_end_i = 1'b0;
  logic       no_hdr_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_ready_o;
  logic       sym_valid_o;
  logic [2:0] sym_kind_o;
  logic [7:0] sym_data_o;
  logic       sym_ready_i = 1'b0;
  logic       busy_o;
  logic       err_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit bus_idle = 1'b1;

  logic [2:0] ek[64];
  logic [7:0] ed[64];
  string      et[64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ccc_frame_seq dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] c, input int i);
    return c ^ 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic podd(input logic [7:0] b);
    return ~(^b);
  endfunction

  task automatic run_msg(input int typ, input logic [7:0] ccc, input int cnt,
                         input bit endb, input bit noh);
    bit reject;
    int n, idx, bi, guard;
    bit pstall;
    logic [2:0] pk;
    logic [7:0] pd;
    reject = (typ != 6) || (ccc == 8'h07 && cnt != 0);
    n = 0;
    if (!reject) begin
      if (bus_idle) begin
        ek[n] = 3'd0; ed[n] = 8'h00; et[n] = "R3"; n++;
        if (!noh) begin ek[n] = 3'd3; ed[n] = 8'hFC; et[n] = "R3"; n++; end
      end else begin
        ek[n] = 3'd3; ed[n] = 8'hFC; et[n] = "R4"; n++;
      end
      ek[n] = 3'd4; ed[n] = ccc; et[n] = "R5"; n++;
      ek[n] = 3'd6; ed[n] = {7'b0, podd(ccc)}; et[n] = "R5"; n++;
      for (int i = 0; i < cnt; i++) begin
        ek[n] = 3'd5; ed[n] = dbyte(ccc, i); et[n] = "R6"; n++;
        ek[n] = 3'd6; ed[n] = {7'b0, podd(dbyte(ccc, i))}; et[n] = "R6"; n++;
      end
      if (ccc[7]) begin ek[n] = 3'd1; et[n] = "R7"; end
      else begin ek[n] = endb ? 3'd2 : 3'd1; et[n] = "R8"; end
      ed[n] = 8'h00; n++;
    end

    @(negedge clk_i);
    desc_valid_i = 1'b1; desc_type_i = 4'(typ); desc_ccc_i = ccc;
    desc_cnt_i = 16'(cnt); desc_end_i = endb; no_hdr_i = noh;
    sym_ready_i = 1'b0; byte_valid_i = 1'b0;
    #1;
    chk(desc_ready_o == 1'b1, "R10", "ready before accept", int'(desc_ready_o), 1);
    @(negedge clk_i);
    desc_valid_i = 1'b0; no_hdr_i = ~noh;
    #1;
    if (reject) begin
      chk(err_o == 1'b1, (typ != 6) ? "R1" : "R2", "err pulse", int'(err_o), 1);
      chk(!busy_o && !sym_valid_o, (typ != 6) ? "R1" : "R2", "no activity",
          int'({busy_o, sym_valid_o}), 0);
      @(negedge clk_i); #1;
      chk(err_o == 1'b0, "R1", "err single cycle", int'(err_o), 0);
      return;
    end
    chk(err_o == 1'b0, "R1", "no err on legal", int'(err_o), 0);
    chk(busy_o && !desc_ready_o, "R10", "busy after accept",
        int'({busy_o, desc_ready_o}), 2);

    idx = 0; bi = 0; guard = 0; pstall = 1'b0; pk = '0; pd = '0;
    while (idx < n && guard < 400) begin
      if (guard > 0) @(negedge clk_i);
      guard++; cyc++;
      sym_ready_i  = (cyc % 3) != 1;
      byte_valid_i = (cyc % 5) != 2;
      byte_i       = dbyte(ccc, bi);
      #1;
      if (pstall)
        chk(sym_valid_o && sym_kind_o == pk && sym_data_o == pd, "R9",
            "stall hold", int'({sym_kind_o, sym_data_o}), int'({pk, pd}));
      pstall = sym_valid_o && !sym_ready_i && sym_kind_o != 3'd5;
      pk = sym_kind_o; pd = sym_data_o;
      if (byte_ready_o && byte_valid_i) bi++;
      if (sym_valid_o && sym_ready_i) begin
        chk(sym_kind_o == ek[idx] && sym_data_o == ed[idx], et[idx], "symbol",
            int'({sym_kind_o, sym_data_o}), int'({ek[idx], ed[idx]}));
        idx++;
      end
    end
    chk(idx == n, "R6", "symbol count", idx, n);
    chk(bi == cnt, "R6", "bytes pulled", bi, cnt);
    @(negedge clk_i);
    sym_ready_i = 1'b1; byte_valid_i = 1'b1;
    #1;
    chk(!busy_o && !sym_valid_o && desc_ready_o, "R10", "idle after end",
        int'({busy_o, sym_valid_o, desc_ready_o}), 1);
    bus_idle = !ccc[7] && endb;
  endtask

  initial begin
    logic [7:0] codes[6];
    codes = '{8'h00, 8'h07, 8'h7F, 8'h80, 8'h9A, 8'hFF};
    #1;
    chk(!busy_o && !sym_valid_o && !err_o && desc_ready_o, "R10", "reset state",
        int'({busy_o, sym_valid_o, err_o, desc_ready_o}), 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int t = 0; t < 16; t++)
      for (int c = 0; c < 6; c++)
        for (int k = 0; k < 4; k++)
          for (int e = 0; e < 2; e++)
            for (int h = 0; h < 2; h++)
              run_msg(t, codes[c], k, e[0], h[0]);
    run_msg(6, 8'h1A, 20, 1'b1, 1'b0);
    run_msg(6, 8'h07, 0, 1'b0, 1'b1);
    run_msg(6, 8'h07, 0, 1'b1, 1'b1);
    run_msg(6, 8'h07, 5, 1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule